// File: doc/BRIEF.md
# Serial ADC Output Interface Emulator

This block reproduces the digital readout side of a 12-bit sampling converter inside a
synchronous system. It runs on one fast system clock. The serial clock and the
conversion-start strobe arrive as already-synchronised inputs, and the block detects
their edges. A sample word is offered on a parallel port and captured when a conversion
begins. That word then leaves on a serial data line, with a separate output-enable that
stands for the line's high-impedance state.

The strobe is active low. When it falls, a conversion starts. The number of serial-clock
rising edges seen before the strobe returns high decides what happens next. The block
can stay ready for back-to-back conversions, or it can drop into partial power-down. It
also tracks that the first complete conversion after reset is only a calibration pass.

A host model or bench uses the block in one of two ways. It toggles the serial clock
16 times per conversion and releases the strobe late to keep converting. Or it releases
the strobe early to put the converter to sleep until the next falling strobe.

Top module: `adc_serial_emu`

## Requirements
- R1: One clock after a falling edge on `cnvst_i`, `dout_oe_o` is 1, `dout_o` is 0, and the value on `sample_i` in that cycle is captured.
- R2: After the k-th rising edge of `sclk_i` in a conversion, `dout_o` shows 0 for k = 1 to 3. For k = 4 to 15 it shows captured bit 15-k, so the MSB comes first. For k = 16 it shows 0. Each value appears one clock after the edge.
- R3: Changes on `sample_i` after the capture cycle do not alter the serial word.
- R4: If `cnvst_i` rises after the 14th or the 15th edge, the conversion goes on to the 16th edge. `dout_oe_o` then falls one clock after that edge, and the power state does not change.
- R5: If `cnvst_i` rises after 3 to 13 edges, `dout_oe_o` falls one clock later. In the normal state, the power state becomes partial power-down (code 2).
- R6: If `cnvst_i` is still low after the 16th edge, `dout_oe_o` falls one clock after whichever comes first: the `cnvst_i` rising edge or the 17th `sclk_i` rising edge.
- R7: While reset is held, `dout_oe_o` is 0, `cal_cycle_o` is 0 and `pwr_state_o` is 0 (calibration pending).
- R8: During the first conversion after reset, `cal_cycle_o` is 1. On its 16th edge the state moves to normal (code 1). If that conversion ends early, the state stays at code 0.
- R9: A falling `cnvst_i` in partial power-down moves the state to normal and starts a conversion, both one clock later.
- R10: If `cnvst_i` rises after fewer than 3 edges, that rise has no effect. The word then runs to the 16th edge.
- R11: Rising `sclk_i` edges with no conversion in progress change neither `dout_oe_o` nor `pwr_state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| sclk_i | input | 1 | Synchronised serial clock |
| cnvst_i | input | 1 | Synchronised active-low conversion strobe |
| sample_i | input | SAMPLE_W | Parallel sample word |
| dout_o | output | 1 | Serial data, 0 while not enabled |
| dout_oe_o | output | 1 | Data line driven (1) or high impedance (0) |
| pwr_state_o | output | 2 | 0 calibration pending, 1 normal, 2 partial power-down |
| cal_cycle_o | output | 1 | Current conversion is the calibration pass |

## Verification
Every response of this block is due exactly one system clock after the input edge
that causes it. This covers the enable on a strobe fall, each new serial bit after a
serial-clock rise, the enable release, and each power-state change, because every input
edge is seen by one register and acted on in that same clock. The bench changes inputs on
the falling clock edge and reads the outputs on the next falling edge, one full cycle
later, so each result has been registered by then. Its model applies the edge-count
windows to predict the enable, the bit and the state after every single edge.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

   typedef enum logic [1:0] {
      PWR_CAL    = 2'd0,
      PWR_NORMAL = 2'd1,
      PWR_PPD    = 2'd2
   } pwr_e;

   // Count width able to hold a saturation limit
   function automatic int cnt_width(input int limit);
      return $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/adc_emu_edge.sv
module adc_emu_edge #(
   parameter bit IDLE_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o,
   output logic fall_o
);
   logic last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= IDLE_LEVEL;
      else        last_q <= sig_i;
   end

   assign rise_o = sig_i & ~last_q;
   assign fall_o = ~sig_i & last_q;
endmodule

// File: rtl/adc_emu_cnt.sv
module adc_emu_cnt #(
   parameter int SAT = 17,
   parameter int CW  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          step_i,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] cnt_inc_o
);
   localparam logic [CW-1:0] SAT_V = CW'(SAT);

   logic [CW-1:0] cnt_q;

   generate
      if (SAT < 1) begin : g_bad_sat
         $error("adc_emu_cnt: SAT must be positive");
      end
   endgenerate

   assign cnt_inc_o = (cnt_q >= SAT_V) ? SAT_V : cnt_q + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (step_i) cnt_q <= cnt_inc_o;
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/adc_emu_shift.sv
module adc_emu_shift #(
   parameter int W    = 12,
   parameter int LEAD = 3,
   parameter int CW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [W-1:0]  sample_i,
   input  logic          step_i,
   input  logic [CW-1:0] cnt_inc_i,
   output logic          bit_o
);
   localparam logic [CW-1:0] FIRST_V = CW'(LEAD + 1);
   localparam logic [CW-1:0] LAST_V  = CW'(LEAD + W);

   logic [W-1:0] word_q;
   logic         bit_q;
   logic         in_data;

   assign in_data = (cnt_inc_i >= FIRST_V) && (cnt_inc_i <= LAST_V);

   generate
      if (W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      word_q <= '0;
            else if (load_i) word_q <= sample_i;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 word_q <= '0;
            else if (load_i)            word_q <= sample_i;
            else if (step_i && in_data) word_q <= {word_q[W-2:0], 1'b0};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (load_i) bit_q <= 1'b0;
      else if (step_i) bit_q <= in_data ? word_q[W-1] : 1'b0;
   end

   assign bit_o = bit_q;
endmodule

// File: rtl/adc_emu_pwr.sv
module adc_emu_pwr
   import adc_emu_pkg::*;
#(
   parameter int W    = 12,
   parameter int LEAD = 3,
   parameter int CW   = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          up_i,
   input  logic          step_i,
   input  logic          strobe_lvl_i,
   input  logic [CW-1:0] cnt_i,
   input  logic [CW-1:0] cnt_inc_i,
   output pwr_e          state_o,
   output logic          busy_o
);
   localparam int FULL = LEAD + W + 1;
   localparam int SAT  = FULL + 1;
   localparam logic [CW-1:0] PPD_LO_V = CW'(LEAD);
   localparam logic [CW-1:0] PPD_HI_V = CW'(LEAD + W - 2);
   localparam logic [CW-1:0] FULL_V   = CW'(FULL);
   localparam logic [CW-1:0] SAT_V    = CW'(SAT);

   pwr_e state_q, state_d;
   logic busy_q, busy_d;
   logic sleep_win, late_up, end_full, end_over, full_hit;

   assign sleep_win = up_i && (cnt_i >= PPD_LO_V) && (cnt_i <= PPD_HI_V);
   assign late_up   = up_i && (cnt_i >= FULL_V);
   assign full_hit  = step_i && (cnt_inc_i == FULL_V);
   assign end_full  = full_hit && strobe_lvl_i;
   assign end_over  = step_i && (cnt_inc_i == SAT_V) && (cnt_i == FULL_V);

   always_comb begin
      busy_d = busy_q;
      if (start_i) busy_d = 1'b1;
      else if (sleep_win || late_up || end_full || end_over) busy_d = 1'b0;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PWR_CAL:    if (full_hit) state_d = PWR_NORMAL;
         PWR_NORMAL: if (sleep_win) state_d = PWR_PPD;
         PWR_PPD:    if (start_i) state_d = PWR_NORMAL;
         default:    state_d = PWR_CAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PWR_CAL;
         busy_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         busy_q  <= busy_d;
      end
   end

   assign state_o = state_q;
   assign busy_o  = busy_q;
endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu
   import adc_emu_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int LEAD_Z   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sclk_i,
   input  logic                cnvst_i,
   input  logic [SAMPLE_W-1:0] sample_i,
   output logic                dout_o,
   output logic                dout_oe_o,
   output logic [1:0]          pwr_state_o,
   output logic                cal_cycle_o
);
   localparam int FULL = LEAD_Z + SAMPLE_W + 1;
   localparam int SAT  = FULL + 1;
   localparam int CW   = cnt_width(SAT);

   generate
      if (SAMPLE_W < 2) begin : g_bad_w
         $error("adc_serial_emu: SAMPLE_W must be at least 2");
      end
      if (LEAD_Z < 1) begin : g_bad_lead
         $error("adc_serial_emu: LEAD_Z must be at least 1");
      end
   endgenerate

   logic sclk_rise, sclk_fall_unused;
   logic cnvst_rise, cnvst_fall;
   logic start, step, up, busy, dbit;
   logic [CW-1:0] cnt, cnt_inc;
   pwr_e state;

   adc_emu_edge #(.IDLE_LEVEL(1'b0)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(sclk_i),
      .rise_o(sclk_rise), .fall_o(sclk_fall_unused)
   );

   adc_emu_edge #(.IDLE_LEVEL(1'b1)) u_strobe_edge (
      .clk(clk), .rst_n(rst_n), .sig_i(cnvst_i),
      .rise_o(cnvst_rise), .fall_o(cnvst_fall)
   );

   assign start = cnvst_fall;
   assign step  = sclk_rise & busy & ~start;
   assign up    = cnvst_rise & busy & ~start;

   adc_emu_cnt #(.SAT(SAT), .CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(start), .step_i(step),
      .cnt_o(cnt), .cnt_inc_o(cnt_inc)
   );

   adc_emu_shift #(.W(SAMPLE_W), .LEAD(LEAD_Z), .CW(CW)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(start), .sample_i(sample_i),
      .step_i(step), .cnt_inc_i(cnt_inc), .bit_o(dbit)
   );

   adc_emu_pwr #(.W(SAMPLE_W), .LEAD(LEAD_Z), .CW(CW)) u_pwr (
      .clk(clk), .rst_n(rst_n), .start_i(start), .up_i(up), .step_i(step),
      .strobe_lvl_i(cnvst_i), .cnt_i(cnt), .cnt_inc_i(cnt_inc),
      .state_o(state), .busy_o(busy)
   );

   assign dout_oe_o   = busy;
   assign dout_o      = busy & dbit;
   assign pwr_state_o = state;
   assign cal_cycle_o = busy && (state == PWR_CAL);
endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cnvst_i,
   input logic       dout_o,
   input logic       dout_oe_o,
   input logic [1:0] pwr_state_o,
   input logic       cal_cycle_o
);
   // R7: reset holds the idle, calibration-pending outputs
   a_r7_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (!dout_oe_o && pwr_state_o == 2'd0 && !cal_cycle_o));

   // R1: strobe fall enables the line with a low level
   a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cnvst_i) |=> (dout_oe_o && !dout_o));

   // R5: partial power-down never drives the line
   a_r5_ppd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state_o == 2'd2) |-> !dout_oe_o);

   // R8: calibration flag only on a driven line while calibration is pending
   a_r8_cal_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cal_cycle_o |-> (dout_oe_o && pwr_state_o == 2'd0));

   // R9: falling strobe in power-down wakes to normal
   a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state_o == 2'd2 && $fell(cnvst_i)) |=> (pwr_state_o == 2'd1));

   // R11: with no conversion and no start, the state holds
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!dout_oe_o && !$fell(cnvst_i)) |=> $stable(pwr_state_o));

   // R2: data is low whenever the line is released
   a_r2_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe_o |-> !dout_o);
endmodule

bind adc_serial_emu adc_serial_emu_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cnvst_i(cnvst_i), .dout_o(dout_o),
   .dout_oe_o(dout_oe_o), .pwr_state_o(pwr_state_o), .cal_cycle_o(cal_cycle_o)
);

// File: tb/adc_serial_emu_tb.sv
`timescale 1ns/1ps
module adc_serial_emu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0;
   logic        cnvst = 1'b1;
   logic [11:0] smp = '0;
   logic        dout, oe, cal;
   logic [1:0]  st;

   always #2.5 clk = ~clk;

   adc_serial_emu u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cnvst_i(cnvst),
      .sample_i(smp), .dout_o(dout), .dout_oe_o(oe),
      .pwr_state_o(st), .cal_cycle_o(cal)
   );

   typedef struct packed {
      logic [11:0] word;
      logic [4:0]  rise_at;
      logic [4:0]  nedg;
      logic [1:0]  st_end;
   } vec_t;

   // word, edges before strobe rises, edges issued, final state
   localparam vec_t VEC [9] = '{
      '{12'hA5C, 5'd16, 5'd16, 2'd1},
      '{12'h3C1, 5'd15, 5'd16, 2'd1},
      '{12'hFFF, 5'd14, 5'd16, 2'd1},
      '{12'h800, 5'd8,  5'd10, 2'd2},
      '{12'h0F0, 5'd20, 5'd17, 2'd1},
      '{12'h123, 5'd3,  5'd5,  2'd2},
      '{12'h7E7, 5'd13, 5'd14, 2'd2},
      '{12'h555, 5'd2,  5'd16, 2'd1},
      '{12'hAAA, 5'd14, 5'd16, 2'd1}
   };

   int n_chk = 0;
   int n_fail = 0;
   int m_cnt = 0;
   bit m_oe = 0;
   bit m_dout = 0;
   int m_st = 0;
   logic [11:0] m_word = '0;

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_outs(input string tag);
      chk({tag, " enable"}, int'(oe), int'(m_oe));
      chk({tag, " data"}, int'(dout), int'(m_dout));
      chk({tag, " state"}, int'(st), m_st);
      chk("R8 calibration flag", int'(cal), int'(m_oe && m_st == 0));
   endtask

   task automatic start_conv(input logic [11:0] w);
      bit woke;
      smp   = w;
      cnvst = 1'b0;
      tick();
      woke   = (m_st == 2);
      m_word = w;
      if (woke) m_st = 1;
      m_oe   = 1;
      m_cnt  = 0;
      m_dout = 0;
      check_outs(woke ? "R9 wake start" : "R1 start");
      smp = ~w; // R3: later changes must not reach the word
   endtask

   task automatic raise_strobe();
      string tag;
      if (m_cnt < 3)       tag = "R10 early rise";
      else if (m_cnt < 14) tag = "R5 sleep window";
      else if (m_cnt < 16) tag = "R4 continuous window";
      else                 tag = "R6 late rise";
      cnvst = 1'b1;
      tick();
      if (m_oe) begin
         if (m_cnt >= 3 && m_cnt <= 13) begin
            m_oe = 0;
            if (m_st == 1) m_st = 2;
         end else if (m_cnt >= 16) begin
            m_oe = 0;
         end
      end
      if (!m_oe) m_dout = 0;
      check_outs(tag);
   endtask

   task automatic sclk_edge(input string tag);
      sclk = 1'b1;
      tick();
      if (m_oe) begin
         m_cnt  = (m_cnt >= 17) ? 17 : m_cnt + 1;
         m_dout = (m_cnt >= 4 && m_cnt <= 15) ? m_word[15 - m_cnt] : 1'b0;
         if (m_cnt == 16) begin
            if (m_st == 0) m_st = 1;
            if (cnvst) m_oe = 0;
         end
         if (m_cnt == 17) m_oe = 0;
      end
      if (!m_oe) m_dout = 0;
      check_outs(tag);
      sclk = 1'b0;
      tick();
   endtask

   task automatic run_vec(input vec_t v);
      start_conv(v.word);
      for (int e = 0; e <= int'(v.nedg); e++) begin
         if (e == int'(v.rise_at)) raise_strobe();
         if (e < int'(v.nedg)) sclk_edge("R2 serial word");
      end
      if (!cnvst) raise_strobe();
      tick();
      chk("R8 final state", int'(st), int'(v.st_end));
   endtask

   initial begin
      #(5.0 * 150000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) tick();
      // R7: outputs while reset is held
      chk("R7 reset enable", int'(oe), 0);
      chk("R7 reset state", int'(st), 0);
      chk("R7 reset calibration flag", int'(cal), 0);
      rst_n = 1'b1;
      tick();

      // R11: serial clock with no conversion in progress
      sclk_edge("R11 idle clock");
      sclk_edge("R11 idle clock");

      // R8: calibration pass cut short leaves calibration pending
      run_vec('{12'h111, 5'd6, 5'd8, 2'd0});

      foreach (VEC[i]) run_vec(VEC[i]);

      // R7: reset again returns to calibration pending
      rst_n = 1'b0;
      tick();
      m_st = 0; m_oe = 0; m_dout = 0;
      check_outs("R7 second reset");
      rst_n = 1'b1;
      tick();
      run_vec('{12'h9C3, 5'd16, 5'd17, 2'd1});

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule